// File: doc/BRIEF.md
# Handset Power Sequencing Controller

This block is the digital decision logic of a battery handset's power-management unit. Comparators and regulators sit outside it and report only logic flags: the battery is above the start level, the battery is above the run level, a charger is present, the die is too hot, the die has cooled down, and the digital rail is in regulation. The block also reads the user power key (active low), a power-hold line from the processor and an analog-enable request. From these it drives the enables of the real-time-clock, digital, analog, reference and oscillator supplies.

It also times the release of an active-low system reset after the digital rail reports power-good, using a loadable cycle count. It gates the SIM supply and passes on the 3 V / 5 V choice for that supply. Every flag passes through a multi-stage synchronizer first. The charger and key flags are then filtered so that pulses shorter than the debounce window have no effect.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, and whenever the start-level lockout is set and the digital supply is off, every supply enable is 0, the RTC enable included. A power key press does not change this.
- R2: With the lockout clear and no thermal block, any one of three conditions turns on the digital, analog and reference enables: charger flag 1, key input 0 (the key is active low), or power-hold 1.
- R3: With the key released and no charger, power-hold alone keeps the main supplies on. When power-hold goes to 0, only the RTC enable stays on.
- R4: Under charger or key turn-on, the oscillator enable is 1. When power-hold is the only source, the oscillator enable copies the analog-enable request.
- R5: The lockout clears when the above-start flag is 1, and the RTC enable then goes to 1. While the digital supply is off, the lockout sets again only when the above-run flag is 0. A drop of the start flag alone leaves the RTC enable on.
- R6: While the digital supply is on, both battery flags are ignored. The main supplies stay on through any change of those flags.
- R7: The over-temperature flag turns off every supply except RTC. They stay off, whatever the key, power-hold and charger inputs are, until the temperature-recovered flag is seen.
- R8: Reset output is 0 from reset and whenever the digital enable is 0 or power-good is 0. Once both are 1, reset goes high on the (N+1)-th such clock, where N is the delay count input. N = 0 releases reset on the first such clock.
- R9: The SIM enable is 0 while the digital enable is 0, the reset output is 0, or the SIM-on input is 0; otherwise it is 1. The SIM select output is 1 (5 V) only when the SIM enable is 1 and the program input is 1; a 0 selects 3 V.
- R10: The RTC enable is 1 whenever the digital enable is 1, even if the lockout path has not started it.
- R11: Every flag is delayed by SYNC_STG clocks. A charger or key level takes effect only after it has been stable for DB_CYC clocks past the synchronizer, so shorter pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bat_start_i | input | 1 | Battery above the start (upper) level |
| bat_run_i | input | 1 | Battery above the run (lower) level |
| chg_det_i | input | 1 | Charger present |
| key_n_i | input | 1 | Power key, 0 = pressed |
| hold_i | input | 1 | Processor power-hold |
| ana_req_i | input | 1 | Oscillator supply request from the processor |
| otemp_i | input | 1 | Die over-temperature |
| trec_i | input | 1 | Die temperature recovered |
| dig_pgood_i | input | 1 | Digital rail in regulation |
| sim_on_i | input | 1 | SIM supply request |
| sim_5v_i | input | 1 | SIM level program, 1 = 5 V |
| rst_dly_i | input | DLY_W | Reset delay count in clocks (quasi-static) |
| rtc_en_o | output | 1 | RTC supply enable |
| dig_en_o | output | 1 | Digital supply enable |
| ana_en_o | output | 1 | Analog supply enable |
| ref_en_o | output | 1 | Reference buffer enable |
| osc_en_o | output | 1 | Oscillator supply enable |
| sys_rst_n_o | output | 1 | System reset, active low |
| sim_en_o | output | 1 | SIM supply enable |
| sim_5v_o | output | 1 | SIM level select, 1 = 5 V |

## Verification
The assertions assume that the flag inputs are level signals that last longer than the synchronizer depth. They also assume that the over-temperature and recovered flags are never both 1 for long; if both are 1, over-temperature wins. The delay count is assumed to change only while the digital supply is off. The stimulus changes inputs only on the falling clock edge and holds each level for many clocks. It changes the delay count only after the supplies have shut down. It drives power-good as a copy of the digital enable, except during one interval where the bench forces it low on purpose.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef struct packed {
      logic bat_start;
      logic bat_run;
      logic chg;
      logic key_n;
      logic hold;
      logic ana_req;
      logic otemp;
      logic trec;
      logic pgood;
      logic sim_on;
      logic sim_5v;
   } pwr_in_t;

   localparam int IN_W = $bits(pwr_in_t);

   // the key idles released (high); every other flag idles low
   localparam pwr_in_t IN_RST = '{key_n: 1'b1, default: 1'b0};

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
   parameter int W = 1,
   parameter int STG = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STG < 2) begin : g_bad_stg
      $error("pwr_sync: STG must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("pwr_sync: W must be positive");
   end

   logic [W-1:0] stg_q [STG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STG; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STG; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STG-1];

endmodule

// File: rtl/pwr_debounce.sv
module pwr_debounce #(
   parameter int CYC = 8,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (CYC < 0) begin : g_bad_cyc
      $error("pwr_debounce: CYC must not be negative");
   end

   if (CYC == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_filt
      localparam int CW = $clog2(CYC + 1);
      logic [CW-1:0] cnt_q;
      logic          lvl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= RST_VAL;
         end else if (d_i == lvl_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(CYC - 1)) begin
            lvl_q <= d_i;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign q_o = lvl_q;

      // R11
      deb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(d_i)));
   end

endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dig_en_i,
   input  logic             pgood_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             rst_n_o
);

   if (DLY_W < 1 || DLY_W > 32) begin : g_bad_w
      $error("pwr_rst_timer: DLY_W out of range");
   end

   logic [DLY_W-1:0] cnt_q;
   logic             rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rel_q <= 1'b0;
      end else if (!dig_en_i || !pgood_i) begin
         cnt_q <= '0;
         rel_q <= 1'b0;
      end else if (!rel_q) begin
         if (cnt_q >= dly_i) rel_q <= 1'b1;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end

   assign rst_n_o = rel_q;

   // R8
   rst_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dig_en_i |=> !rst_n_o);

endmodule

// File: rtl/pwr_sim_gate.sv
module pwr_sim_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic dig_en_i,
   input  logic sys_rst_n_i,
   input  logic sim_on_i,
   input  logic sel_5v_i,
   output logic sim_en_o,
   output logic sim_5v_o
);

   logic en_d;

   assign en_d = dig_en_i & sys_rst_n_i & sim_on_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sim_en_o <= 1'b0;
         sim_5v_o <= 1'b0;
      end else begin
         sim_en_o <= en_d;
         sim_5v_o <= en_d & sel_5v_i;
      end
   end

   // R9
   sim_rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_rst_n_i |=> !sim_en_o);

   // R9
   sim_dig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dig_en_i |=> (!sim_en_o && !sim_5v_o));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int SYNC_STG = 2,
   parameter int DB_CYC   = 8,
   parameter int DLY_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bat_start_i,
   input  logic             bat_run_i,
   input  logic             chg_det_i,
   input  logic             key_n_i,
   input  logic             hold_i,
   input  logic             ana_req_i,
   input  logic             otemp_i,
   input  logic             trec_i,
   input  logic             dig_pgood_i,
   input  logic             sim_on_i,
   input  logic             sim_5v_i,
   input  logic [DLY_W-1:0] rst_dly_i,
   output logic             rtc_en_o,
   output logic             dig_en_o,
   output logic             ana_en_o,
   output logic             ref_en_o,
   output logic             osc_en_o,
   output logic             sys_rst_n_o,
   output logic             sim_en_o,
   output logic             sim_5v_o
);

   pwr_in_t         raw_in;
   pwr_in_t         syn_in;
   logic [IN_W-1:0] syn_vec;

   assign raw_in = '{bat_start: bat_start_i, bat_run: bat_run_i, chg: chg_det_i,
                     key_n: key_n_i, hold: hold_i, ana_req: ana_req_i,
                     otemp: otemp_i, trec: trec_i, pgood: dig_pgood_i,
                     sim_on: sim_on_i, sim_5v: sim_5v_i};

   pwr_sync #(.W(IN_W), .STG(SYNC_STG), .RST_VAL(IN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_vec)
   );
   assign syn_in = pwr_in_t'(syn_vec);

   logic chg_f, key_n_f;

   pwr_debounce #(.CYC(DB_CYC), .RST_VAL(1'b0)) u_deb_chg (
      .clk (clk), .rst_n (rst_n), .d_i (syn_in.chg), .q_o (chg_f)
   );
   pwr_debounce #(.CYC(DB_CYC), .RST_VAL(1'b1)) u_deb_key (
      .clk (clk), .rst_n (rst_n), .d_i (syn_in.key_n), .q_o (key_n_f)
   );

   // power-state decisions
   logic lock_q, therm_q, dig_en_q, osc_en_q;
   logic forced_src, turn_req, main_d;

   assign forced_src = chg_f | ~key_n_f;
   assign turn_req   = forced_src | syn_in.hold;
   assign main_d     = turn_req & ~therm_q & ~syn_in.otemp & (~lock_q | dig_en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q   <= 1'b1;
         therm_q  <= 1'b0;
         dig_en_q <= 1'b0;
         osc_en_q <= 1'b0;
      end else begin
         dig_en_q <= main_d;
         osc_en_q <= main_d & (forced_src | syn_in.ana_req);
         if (syn_in.otemp)     therm_q <= 1'b1;
         else if (syn_in.trec) therm_q <= 1'b0;
         if (!dig_en_q) begin
            if (syn_in.bat_start)    lock_q <= 1'b0;
            else if (!syn_in.bat_run) lock_q <= 1'b1;
         end
      end
   end

   logic sys_rst_n;

   pwr_rst_timer #(.DLY_W(DLY_W)) u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .dig_en_i (dig_en_q),
      .pgood_i  (syn_in.pgood),
      .dly_i    (rst_dly_i),
      .rst_n_o  (sys_rst_n)
   );

   pwr_sim_gate u_sim (
      .clk         (clk),
      .rst_n       (rst_n),
      .dig_en_i    (dig_en_q),
      .sys_rst_n_i (sys_rst_n),
      .sim_on_i    (syn_in.sim_on),
      .sel_5v_i    (syn_in.sim_5v),
      .sim_en_o    (sim_en_o),
      .sim_5v_o    (sim_5v_o)
   );

   assign rtc_en_o    = ~lock_q | dig_en_q;
   assign dig_en_o    = dig_en_q;
   assign ana_en_o    = dig_en_q;
   assign ref_en_o    = dig_en_q;
   assign osc_en_o    = osc_en_q;
   assign sys_rst_n_o = sys_rst_n;

   // R7
   therm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      therm_q |-> !dig_en_q);

   // R4
   osc_needs_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en_q |-> dig_en_q);

   // R6
   lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_en_q && $past(dig_en_q)) |-> (lock_q == $past(lock_q)));

   // R1
   lock_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !dig_en_q) |=> !dig_en_q);

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;

   localparam int DB  = 4;
   localparam int DW  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bat_start = 0, bat_run = 0, chg = 0, key_n = 1, hold = 0, ana = 0;
   logic otemp = 0, trec = 0, pgood = 0, sim_on = 0, sim_5v = 0;
   logic pg_force_low = 0;
   logic [DW-1:0] dly = 8'd5;
   logic rtc_en, dig_en, ana_en, ref_en, osc_en, srst_n, sim_en, sim5;

   always #4 clk = ~clk;

   pwr_seq_ctrl #(.SYNC_STG(2), .DB_CYC(DB), .DLY_W(DW)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .bat_start_i (bat_start), .bat_run_i (bat_run), .chg_det_i (chg),
      .key_n_i (key_n), .hold_i (hold), .ana_req_i (ana), .otemp_i (otemp),
      .trec_i (trec), .dig_pgood_i (pgood), .sim_on_i (sim_on),
      .sim_5v_i (sim_5v), .rst_dly_i (dly),
      .rtc_en_o (rtc_en), .dig_en_o (dig_en), .ana_en_o (ana_en),
      .ref_en_o (ref_en), .osc_en_o (osc_en), .sys_rst_n_o (srst_n),
      .sim_en_o (sim_en), .sim_5v_o (sim5)
   );

   // reference model: each input travels through a two-entry queue
   bit q_in [$][11];
   bit m_lk, m_th, m_dg, m_os, m_rn, m_se, m_s5, m_chg, m_key;
   int m_rc, m_cc, m_kc;
   int vectors = 0, errors = 0;
   string phase = "R1";
   bit done = 0;

   task automatic model_reset();
      q_in.delete();
      for (int i = 0; i < 2; i++) q_in.push_back('{0,0,0,1,0,0,0,0,0,0,0});
      m_lk = 1; m_th = 0; m_dg = 0; m_os = 0; m_rn = 0; m_se = 0; m_s5 = 0;
      m_chg = 0; m_key = 1; m_rc = 0; m_cc = 0; m_kc = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         bit s[11];
         bit req, ndg, nos, frc, nse;
         s = q_in[0];
         frc = m_chg || !m_key;
         req = frc || s[4];
         ndg = req && !m_th && !s[6] && (!m_lk || m_dg);
         nos = ndg && (frc || s[5]);
         nse = m_dg && m_rn && s[9];
         m_s5 = nse && s[10];
         m_se = nse;
         if (!m_dg || !s[8]) begin m_rc = 0; m_rn = 0; end
         else if (!m_rn) begin
            if (m_rc >= int'(dly)) m_rn = 1; else m_rc++;
         end
         if (!m_dg) begin
            if (s[0]) m_lk = 0; else if (!s[1]) m_lk = 1;
         end
         if (s[6]) m_th = 1; else if (s[7]) m_th = 0;
         m_dg = ndg; m_os = nos;
         if (s[2] == m_chg) m_cc = 0;
         else if (m_cc == DB - 1) begin m_chg = s[2]; m_cc = 0; end
         else m_cc++;
         if (s[3] == m_key) m_kc = 0;
         else if (m_kc == DB - 1) begin m_key = s[3]; m_kc = 0; end
         else m_kc++;
         void'(q_in.pop_front());
         q_in.push_back('{bat_start, bat_run, chg, key_n, hold, ana, otemp,
                          trec, pgood, sim_on, sim_5v});
      end
   end

   task automatic cmp(string name, logic act, bit exp);
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s t=%0t act=%b exp=%b", phase, name, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         vectors++;
         cmp("rtc_en (R10)", rtc_en, !m_lk || m_dg);
         cmp("dig_en (R2)",  dig_en, m_dg);
         cmp("ana_en (R2)",  ana_en, m_dg);
         cmp("ref_en (R2)",  ref_en, m_dg);
         cmp("osc_en (R4)",  osc_en, m_os);
         cmp("sys_rst_n (R8)", srst_n, m_rn);
         cmp("sim_en (R9)",  sim_en, m_se);
         cmp("sim_5v (R9)",  sim5,   m_s5);
      end
      pgood <= dig_en && !pg_force_low;
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_lvl(string tag, logic act, bit exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s directed t=%0t act=%b exp=%b", tag, $time, act, exp);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL all requirements: watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      wait_cyc(4);
      rst_n = 1;
      wait_cyc(2);
      // R1 reset state, lockout blocks key
      phase = "R1";
      expect_lvl("R1", rtc_en, 0);
      key_n = 0; wait_cyc(20);
      expect_lvl("R1", dig_en, 0);
      key_n = 1; wait_cyc(10);
      // R5 hysteresis
      phase = "R5";
      bat_run = 1; wait_cyc(10);
      expect_lvl("R5", rtc_en, 0);
      bat_start = 1; wait_cyc(10);
      expect_lvl("R5", rtc_en, 1);
      bat_start = 0; wait_cyc(10);
      expect_lvl("R5", rtc_en, 1);
      bat_run = 0; wait_cyc(10);
      expect_lvl("R5", rtc_en, 0);
      bat_run = 1; bat_start = 1; wait_cyc(10);
      // R11 short key pulse ignored
      phase = "R11";
      key_n = 0; wait_cyc(2); key_n = 1; wait_cyc(12);
      expect_lvl("R11", dig_en, 0);
      // R2 key turn-on, R8 reset delay, R9 SIM
      phase = "R2";
      sim_on = 1;
      key_n = 0; wait_cyc(8);
      expect_lvl("R2", dig_en, 1);
      expect_lvl("R4", osc_en, 1);
      expect_lvl("R8", srst_n, 0);
      phase = "R8";
      wait_cyc(10);
      expect_lvl("R8", srst_n, 1);
      phase = "R9";
      expect_lvl("R9", sim_en, 1);
      expect_lvl("R9", sim5, 0);
      sim_5v = 1; wait_cyc(5);
      expect_lvl("R9", sim5, 1);
      sim_on = 0; wait_cyc(5);
      expect_lvl("R9", sim_en, 0);
      sim_on = 1;
      phase = "R8";
      pg_force_low = 1; wait_cyc(6);
      expect_lvl("R8", srst_n, 0);
      pg_force_low = 0; wait_cyc(14);
      // R3 hold takes over, R4 follows ana request
      phase = "R3";
      hold = 1; wait_cyc(3); key_n = 1; wait_cyc(10);
      expect_lvl("R3", dig_en, 1);
      phase = "R4";
      expect_lvl("R4", osc_en, 0);
      ana = 1; wait_cyc(5);
      expect_lvl("R4", osc_en, 1);
      ana = 0; wait_cyc(5);
      // R6 battery flags ignored while on
      phase = "R6";
      bat_start = 0; bat_run = 0; wait_cyc(10);
      expect_lvl("R6", dig_en, 1);
      expect_lvl("R10", rtc_en, 1);
      phase = "R3";
      hold = 0; wait_cyc(8);
      expect_lvl("R3", dig_en, 0);
      expect_lvl("R1", rtc_en, 0);
      expect_lvl("R9", sim_en, 0);
      bat_run = 1; bat_start = 1; wait_cyc(10);
      // R2 charger turn-on with forced oscillator
      phase = "R2";
      dly = 8'd0;
      chg = 1; wait_cyc(12);
      expect_lvl("R2", dig_en, 1);
      expect_lvl("R4", osc_en, 1);
      expect_lvl("R8", srst_n, 1);
      // R7 thermal block
      phase = "R7";
      hold = 1; key_n = 0;
      otemp = 1; wait_cyc(4); otemp = 0; wait_cyc(20);
      expect_lvl("R7", dig_en, 0);
      expect_lvl("R7", rtc_en, 1);
      trec = 1; wait_cyc(4); trec = 0; wait_cyc(10);
      expect_lvl("R7", dig_en, 1);
      chg = 0; key_n = 1; hold = 0; wait_cyc(20);
      // R2 power-hold alone
      phase = "R2";
      hold = 1; wait_cyc(6);
      expect_lvl("R2", dig_en, 1);
      hold = 0; wait_cyc(10);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule